// File: doc/BRIEF.md
# Instruction Prefetch Unit with Shadow Fetch Pointer

This block stands between an execution core and a memory port that is either one or two bytes wide. It keeps a private copy of the program counter, the shadow fetch pointer, and uses it to fill a four-byte instruction queue ahead of the core. Each completed fetch moves the pointer on by the number of bytes it returned. The core reads instruction bytes one at a time through a valid/ready stream. The core never sees the queue itself. Only the timing of byte delivery changes when the memory inserts wait states.

When the core takes a branch, it pulses a reload request. The queued bytes are discarded on that same edge. The core then sends the new fetch address over an 8-bit path, one byte per beat, low byte first. Fetching restarts from the new address once the last beat has been taken. The core can also issue data reads at its own address. These reads share the memory port with fetches but never move the shadow pointer.

Back-pressure works as follows. An instruction byte leaves the queue only on a clock edge where `ib_valid` and `ib_ready` are both high. A data read is presented with `dr_valid` together with a stable address and width, and it is held until `dr_done`. A memory request holds its address and width until `mem_ack`, and the read data is taken on the acknowledging edge.

Top module: `pfu_top`

## Requirements
- R1: While reset is asserted, `ib_valid` is 0. In the first cycle after reset is released, the unit requests a fetch at the reset pointer 0x0100, and the request is a word fetch when `port_wide` is 1.
- R2: Instruction bytes are delivered in strictly ascending address order from the current fetch address. After every completed fetch, the shadow pointer moves on by the number of bytes that fetch returned.
- R3: The queue holds at most 4 bytes. While `ib_ready` stays low, fetching stops once the queue cannot accept another fetch, and `mem_req` stays 0.
- R4: A fetch is a word access (`mem_word`=1) exactly when `port_wide`=1 and the pointer is even. Otherwise it is a byte access. A byte access returns its byte on `mem_rdata[7:0]`. A word access returns the even-address byte on bits 7:0 and the next byte on bits 15:8.
- R5: On the rising edge that samples `reload_start`, all queued bytes are discarded, so `ib_valid` is 0 in the next cycle. The unit then takes the new address on the next two edges with `beat_valid` high, low byte first. No fetch is requested until both beats have been taken.
- R6: Suppose the beats follow on the two edges right after the reload edge and the memory acknowledges at once. Then the first byte of the new stream is valid after the third rising edge following the reload edge, which is four cycles from the reload request.
- R7: A data read uses `dr_addr` and `dr_word`, and `dr_done` is high in the acknowledging cycle with the memory data on `dr_rdata`. A word read places the byte at `dr_addr` in bits 7:0 and the next byte in bits 15:8. Data reads leave the shadow pointer unchanged.
- R8: When no memory transfer is in progress, a waiting data read is issued before a new fetch.
- R9: Once `mem_req` is high without `mem_ack`, the next cycle keeps `mem_req` high with the same `mem_addr` and `mem_word`. A transfer in progress therefore completes before any other is issued.
- R10: A fetch still in flight when a reload arrives is discarded on its acknowledge. It neither enters the queue nor moves the pointer, so the first byte delivered after the reload comes from the new address.
- R11: A byte is removed from the queue only on an edge where `ib_valid` and `ib_ready` are both high. Otherwise `ib_data` keeps presenting the same byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_wide | input | 1 | 1 = memory port is 16 bits wide, 0 = 8 bits |
| reload_start | input | 1 | Pulse: flush the queue and begin a pointer reload |
| beat_valid | input | 1 | An address byte is present on `beat_data` |
| beat_data | input | 8 | Address byte of the reload, low byte first |
| ib_valid | output | 1 | Instruction byte available |
| ib_data | output | 8 | Instruction byte at the head of the queue |
| ib_ready | input | 1 | Core accepts the head byte |
| dr_valid | input | 1 | Data read requested, held until `dr_done` |
| dr_addr | input | 16 | Data read address |
| dr_word | input | 1 | 1 = word data read, 0 = byte |
| dr_done | output | 1 | Data read completes this cycle |
| dr_rdata | output | 16 | Data read result, valid with `dr_done` |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_addr | output | 16 | Memory address |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_ack | input | 1 | Memory completes the request this cycle |
| mem_rdata | input | 16 | Memory read data, valid with `mem_ack` |

## Verification
The hardest situation to reach from the ports is a reload that arrives while a fetch is still waiting on a slow memory. In that case the acknowledge comes back after the pointer has already been reloaded, and the stale bytes must not reach the core. The stimulus forces this with a fixed three-cycle memory wait and a second branch issued right after the first fetch of a new stream. It then checks that the first delivered byte belongs to the second target. A second directed case places a data read in the very cycle a reloaded stream would start fetching, to show that the data read wins and that the fetch which follows still starts at the reloaded address. Random branches, data reads, port widths, wait states and core stalls are then checked against a byte-by-byte model of the instruction stream.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  typedef enum logic {
    PS_RUN  = 1'b0,
    PS_LOAD = 1'b1
  } ptr_state_e;

  typedef logic [1:0] push_cnt_t;

endpackage

// File: rtl/pfu_byteq.sv
module pfu_byteq
  import pfu_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  push_cnt_t     push_n,
  input  logic [7:0]    push_lo,
  input  logic [7:0]    push_hi,
  input  logic          pop_req,
  output logic          out_valid,
  output logic [7:0]    out_data,
  output logic [CW-1:0] free
);

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [7:0]    slot [DEPTH];
  logic [IW-1:0] rd_i, wr_i;
  logic [CW-1:0] cnt;
  logic          do_pop;

  function automatic logic [IW-1:0] nxt(input logic [IW-1:0] i);
    return (i == IW'(DEPTH - 1)) ? '0 : i + 1'b1;
  endfunction

  assign out_valid = (cnt != '0);
  assign out_data  = slot[rd_i];
  assign free      = CW'(DEPTH) - cnt;
  assign do_pop    = pop_req && out_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_i <= '0;
      wr_i <= '0;
      cnt  <= '0;
    end else if (flush) begin
      rd_i <= '0;
      wr_i <= '0;
      cnt  <= '0;
    end else begin
      if (push_n == 2'd2)      wr_i <= nxt(nxt(wr_i));
      else if (push_n == 2'd1) wr_i <= nxt(wr_i);
      if (do_pop) rd_i <= nxt(rd_i);
      cnt <= cnt + CW'(push_n) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (push_n != 2'd0) slot[wr_i] <= push_lo;
      if (push_n == 2'd2) slot[nxt(wr_i)] <= push_hi;
    end
  end

  // R3: a push never exceeds the space left in the queue
  p_push_fits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_n != 2'd0 && !flush) |-> (CW'(push_n) <= free));

endmodule

// File: rtl/pfu_shadow_ptr.sv
module pfu_shadow_ptr
  import pfu_pkg::*;
#(
  parameter int                ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] RST_PTR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              beat_valid,
  input  logic [7:0]        beat_data,
  input  logic              take,
  input  logic              take_two,
  output logic [ADDR_W-1:0] ptr,
  output logic              running
);

  localparam int BEATS = ADDR_W / 8;
  localparam int BW    = (BEATS > 1) ? $clog2(BEATS) : 1;

  ptr_state_e        st;
  logic [BW-1:0]     beat_idx;
  logic [ADDR_W-1:0] stage, stage_nx;
  logic              last_beat;

  assign running   = (st == PS_RUN);
  assign last_beat = (beat_idx == BW'(BEATS - 1));

  always_comb begin
    stage_nx = stage;
    stage_nx[int'(beat_idx)*8 +: 8] = beat_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= PS_RUN;
      ptr      <= RST_PTR;
      beat_idx <= '0;
      stage    <= '0;
    end else if (reload) begin
      st       <= PS_LOAD;
      beat_idx <= '0;
    end else begin
      case (st)
        PS_RUN: begin
          if (take) ptr <= ptr + (take_two ? ADDR_W'(2) : ADDR_W'(1));
        end
        PS_LOAD: begin
          if (beat_valid) begin
            stage <= stage_nx;
            if (last_beat) begin
              ptr <= stage_nx;
              st  <= PS_RUN;
            end else begin
              beat_idx <= beat_idx + 1'b1;
            end
          end
        end
        default: st <= PS_RUN;
      endcase
    end
  end

  // R10: an accepted fetch result only arrives while the pointer is running
  p_take_running_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> running);

  // R7: without a taken fetch or reload the pointer does not move
  p_ptr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !reload && !take) |=> (ptr == $past(ptr)));

endmodule

// File: rtl/pfu_mem_arb.sv
module pfu_mem_arb #(
  parameter int ADDR_W = 16,
  parameter int CW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload,
  input  logic              dr_valid,
  input  logic [ADDR_W-1:0] dr_addr,
  input  logic              dr_word,
  input  logic              fetch_ok,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              fetch_wide,
  input  logic [CW-1:0]     free,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_word,
  input  logic              mem_ack,
  output logic              dr_done,
  output logic              take,
  output logic              take_two
);

  logic              held_v, held_data, held_wide, held_stale;
  logic [ADDR_W-1:0] held_addr;
  logic              fetch_want, cur_valid, cur_data, cur_wide, cur_stale;
  logic [ADDR_W-1:0] cur_addr;
  logic [CW-1:0]     need;

  assign need       = fetch_wide ? CW'(2) : CW'(1);
  assign fetch_want = fetch_ok && (free >= need);

  always_comb begin
    if (held_v) begin
      cur_valid = 1'b1;
      cur_data  = held_data;
      cur_wide  = held_wide;
      cur_addr  = held_addr;
    end else if (dr_valid) begin
      cur_valid = 1'b1;
      cur_data  = 1'b1;
      cur_wide  = dr_word;
      cur_addr  = dr_addr;
    end else begin
      cur_valid = fetch_want;
      cur_data  = 1'b0;
      cur_wide  = fetch_wide;
      cur_addr  = fetch_addr;
    end
  end

  assign cur_stale = held_v && held_stale;
  assign mem_req   = cur_valid;
  assign mem_addr  = cur_addr;
  assign mem_word  = cur_wide;
  assign dr_done   = mem_req && mem_ack && cur_data;
  assign take      = mem_req && mem_ack && !cur_data && !cur_stale && !reload;
  assign take_two  = cur_wide;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_v     <= 1'b0;
      held_data  <= 1'b0;
      held_wide  <= 1'b0;
      held_stale <= 1'b0;
      held_addr  <= '0;
    end else if (mem_req && !mem_ack) begin
      held_v     <= 1'b1;
      held_data  <= cur_data;
      held_wide  <= cur_wide;
      held_addr  <= cur_addr;
      held_stale <= cur_stale || (reload && !cur_data);
    end else begin
      held_v     <= 1'b0;
      held_stale <= 1'b0;
    end
  end

  // R9: an unacknowledged request keeps its address and width
  p_hold_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_word)));

endmodule

// File: rtl/pfu_top.sv
module pfu_top
  import pfu_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DEPTH   = 4,
  parameter logic [ADDR_W-1:0] RST_PTR = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_wide,
  input  logic              reload_start,
  input  logic              beat_valid,
  input  logic [7:0]        beat_data,
  output logic              ib_valid,
  output logic [7:0]        ib_data,
  input  logic              ib_ready,
  input  logic              dr_valid,
  input  logic [ADDR_W-1:0] dr_addr,
  input  logic              dr_word,
  output logic              dr_done,
  output logic [15:0]       dr_rdata,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_word,
  input  logic              mem_ack,
  input  logic [15:0]       mem_rdata
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [ADDR_W-1:0] ptr;
  logic              running, take, take_two, fetch_ok, fetch_wide;
  logic [CW-1:0]     free;
  push_cnt_t         push_n;

  assign fetch_ok   = running && !reload_start;
  assign fetch_wide = port_wide && !ptr[0];
  assign push_n     = take ? (take_two ? 2'd2 : 2'd1) : 2'd0;
  assign dr_rdata   = mem_rdata;

  pfu_shadow_ptr #(.ADDR_W(ADDR_W), .RST_PTR(RST_PTR)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload_start),
    .beat_valid (beat_valid),
    .beat_data  (beat_data),
    .take       (take),
    .take_two   (take_two),
    .ptr        (ptr),
    .running    (running)
  );

  pfu_mem_arb #(.ADDR_W(ADDR_W), .CW(CW)) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .reload     (reload_start),
    .dr_valid   (dr_valid),
    .dr_addr    (dr_addr),
    .dr_word    (dr_word),
    .fetch_ok   (fetch_ok),
    .fetch_addr (ptr),
    .fetch_wide (fetch_wide),
    .free       (free),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_word   (mem_word),
    .mem_ack    (mem_ack),
    .dr_done    (dr_done),
    .take       (take),
    .take_two   (take_two)
  );

  pfu_byteq #(.DEPTH(DEPTH)) u_q (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (reload_start),
    .push_n    (push_n),
    .push_lo   (mem_rdata[7:0]),
    .push_hi   (mem_rdata[15:8]),
    .pop_req   (ib_ready),
    .out_valid (ib_valid),
    .out_data  (ib_data),
    .free      (free)
  );

  // R5: the queue is empty right after a reload request
  p_flush_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    reload_start |=> !ib_valid);

endmodule

// File: tb/sim_pfu_top.sv
`timescale 1ns/1ps
module sim_pfu_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        port_wide = 1'b1;
  logic        reload_start = 1'b0;
  logic        beat_valid = 1'b0;
  logic [7:0]  beat_data = 8'h00;
  logic        ib_valid;
  logic [7:0]  ib_data;
  logic        ib_ready = 1'b0;
  logic        dr_valid = 1'b0;
  logic [15:0] dr_addr = 16'h0000;
  logic        dr_word = 1'b0;
  logic        dr_done;
  logic [15:0] dr_rdata;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_word;
  logic        mem_ack = 1'b0;
  logic [15:0] mem_rdata = 16'h0000;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit hold_ready = 1;
  bit jumping = 0;
  bit rand_wait = 0;
  int max_wait = 0;
  logic [15:0] exp_addr = 16'h0100;

  always #5 clk = ~clk;

  pfu_top u0 (
    .clk(clk), .rst_n(rst_n), .port_wide(port_wide),
    .reload_start(reload_start), .beat_valid(beat_valid), .beat_data(beat_data),
    .ib_valid(ib_valid), .ib_data(ib_data), .ib_ready(ib_ready),
    .dr_valid(dr_valid), .dr_addr(dr_addr), .dr_word(dr_word),
    .dr_done(dr_done), .dr_rdata(dr_rdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_word(mem_word),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] byte_at(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // inputs change at negedge+1, memory answers at +2, outputs sampled at +3
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  // memory model
  bit in_txn = 0;
  int wcnt = 0;
  always begin
    @(negedge clk);
    #2;
    if (mem_req) begin
      if (!in_txn) begin
        in_txn = 1;
        wcnt = rand_wait ? $urandom_range(0, max_wait) : max_wait;
      end
      if (wcnt == 0) begin
        mem_ack = 1'b1;
        mem_rdata = mem_word ? {byte_at(mem_addr + 16'd1), byte_at(mem_addr)}
                             : {8'h00, byte_at(mem_addr)};
        in_txn = 0;
      end else begin
        mem_ack = 1'b0;
        wcnt--;
      end
    end else begin
      mem_ack = 1'b0;
      in_txn = 0;
    end
  end

  // core stream model and instruction byte checker
  always begin
    @(negedge clk);
    #1;
    if (!rst_n || hold_ready || jumping) ib_ready = 1'b0;
    else ib_ready = ($urandom_range(0, 3) != 0);
    #2;
    if (rst_n && ib_valid && ib_ready) begin
      chk(ib_data == byte_at(exp_addr), "R2 R11 stream byte", {16'h0, ib_data},
          {16'h0, byte_at(exp_addr)});
      exp_addr = exp_addr + 16'd1;
    end
  end

  // memory request monitor
  bit prev_pend = 0;
  logic [15:0] prev_addr = 16'h0;
  bit prev_word = 0;
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      if (prev_pend)
        chk(mem_req && mem_addr == prev_addr && mem_word == prev_word,
            "R9 request held", {15'h0, mem_req, mem_addr}, {16'h1, prev_addr});
      else if (mem_req && !dr_valid)
        chk(mem_word == (port_wide && !mem_addr[0]), "R4 fetch width",
            {31'h0, mem_word}, {31'h0, port_wide && !mem_addr[0]});
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
      prev_word = mem_word;
    end else begin
      prev_pend = 0;
    end
  end

  task automatic do_jump(input logic [15:0] a);
    jumping = 1;
    step();
    reload_start = 1'b1;
    exp_addr = a;
    step();
    reload_start = 1'b0;
    beat_valid = 1'b1;
    beat_data = a[7:0];
    step();
    beat_data = a[15:8];
    step();
    beat_valid = 1'b0;
    #1.5;
    jumping = 0;
  endtask

  task automatic do_read(input logic [15:0] a, input bit w);
    logic [15:0] e;
    bit got;
    e = w ? {byte_at(a + 16'd1), byte_at(a)} : {8'h00, byte_at(a)};
    got = 0;
    step();
    dr_valid = 1'b1;
    dr_addr = a;
    dr_word = w;
    for (int i = 0; i < 60 && !got; i++) begin
      #2;
      if (dr_done) begin
        got = 1;
        chk(dr_rdata == e, "R7 data read result", {16'h0, dr_rdata}, {16'h0, e});
      end
      step();
    end
    if (!got) chk(1'b0, "R7 data read never completed", 32'h0, 32'h1);
    dr_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] a;
    bit seen;
    void'($urandom(32'h00C0FFEE));

    // R1: reset state
    repeat (3) step();
    #2;
    chk(ib_valid == 1'b0, "R1 ib_valid in reset", {31'h0, ib_valid}, 32'h0);
    step();
    rst_n = 1'b1;
    #2;
    chk(mem_req && mem_addr == 16'h0100 && mem_word,
        "R1 first fetch", {14'h0, mem_req, mem_word, mem_addr}, {14'h0, 2'b11, 16'h0100});

    // R3: stalled core, queue fills and fetching stops
    repeat (10) step();
    #2;
    chk(mem_req == 1'b0, "R3 fetch stops when full", {31'h0, mem_req}, 32'h0);
    chk(ib_valid && ib_data == byte_at(16'h0100), "R3 R11 head byte held",
        {23'h0, ib_valid, ib_data}, {23'h1, byte_at(16'h0100)});

    // R5 / R6: reload to an odd address, zero-wait memory
    a = 16'h2345;
    jumping = 1;
    step();
    reload_start = 1'b1;
    exp_addr = a;
    step();
    reload_start = 1'b0;
    beat_valid = 1'b1;
    beat_data = a[7:0];
    #2;
    chk(ib_valid == 1'b0, "R5 queue flushed", {31'h0, ib_valid}, 32'h0);
    chk(mem_req == 1'b0, "R5 no fetch during load", {31'h0, mem_req}, 32'h0);
    step();
    beat_data = a[15:8];
    #2;
    chk(mem_req == 1'b0, "R5 no fetch before last beat", {31'h0, mem_req}, 32'h0);
    step();
    beat_valid = 1'b0;
    #2;
    chk(mem_req && mem_addr == a && !mem_word, "R5 R4 fetch at new odd address",
        {14'h0, mem_req, mem_word, mem_addr}, {14'h0, 2'b10, a});
    step();
    #2;
    chk(ib_valid && ib_data == byte_at(a), "R6 first new byte after four cycles",
        {23'h0, ib_valid, ib_data}, {23'h1, byte_at(a)});
    jumping = 0;
    hold_ready = 0;
    repeat (20) step();

    // R8 / R7: data read competes with the first fetch of a new stream
    hold_ready = 1;
    repeat (8) step();
    a = 16'h4000;
    jumping = 1;
    step();
    reload_start = 1'b1;
    exp_addr = a;
    step();
    reload_start = 1'b0;
    beat_valid = 1'b1;
    beat_data = a[7:0];
    step();
    beat_data = a[15:8];
    step();
    beat_valid = 1'b0;
    dr_valid = 1'b1;
    dr_addr = 16'h1234;
    dr_word = 1'b1;
    #2;
    chk(mem_req && mem_addr == 16'h1234 && mem_word, "R8 data read first",
        {14'h0, mem_req, mem_word, mem_addr}, {14'h0, 2'b11, 16'h1234});
    chk(dr_done && dr_rdata == {byte_at(16'h1235), byte_at(16'h1234)},
        "R7 word read lanes", {15'h0, dr_done, dr_rdata},
        {15'h1, byte_at(16'h1235), byte_at(16'h1234)});
    step();
    dr_valid = 1'b0;
    #2;
    chk(mem_req && mem_addr == a && mem_word, "R7 pointer untouched by read",
        {14'h0, mem_req, mem_word, mem_addr}, {14'h0, 2'b11, a});
    jumping = 0;
    hold_ready = 0;
    repeat (20) step();

    // R10: reload while a slow fetch is in flight
    max_wait = 3;
    do_jump(16'h5000);
    #2;
    chk(mem_req && mem_addr == 16'h5000, "R10 slow fetch issued",
        {15'h0, mem_req, mem_addr}, {16'h1, 16'h5000});
    hold_ready = 1;
    do_jump(16'h6003);
    seen = 0;
    for (int i = 0; i < 40 && !seen; i++) begin
      #2;
      if (ib_valid) seen = 1;
      else step();
    end
    chk(seen && ib_data == byte_at(16'h6003), "R10 stale fetch discarded",
        {23'h0, seen, ib_data}, {23'h1, byte_at(16'h6003)});
    hold_ready = 0;
    repeat (30) step();

    // mixed random traffic
    rand_wait = 1;
    max_wait = 2;
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 3) begin
        port_wide = $urandom_range(0, 1);
        do_jump(16'($urandom_range(0, 65535)));
      end else if (r < 8) begin
        bit w;
        w = $urandom_range(0, 1);
        a = 16'($urandom_range(0, 65535));
        if (w) a[0] = 1'b0;
        do_read(a, w);
      end else begin
        step();
      end
    end
    repeat (10) step();

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule